// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends bytes over a two-wire clock-and-data link on which it is the clock master. Software hands it a byte and an optional ninth bit through a valid/ready write port. The word waits in a one-entry holding buffer. When the shift stage is free, the word moves into it in a single system cycle and goes out least significant bit first. The block drives the link clock while the word is shifted. The link is half-duplex, so a receive-inhibit output stays high for as long as a word is being shifted.

The bit rate comes from a divider input. One bit lasts 4 × (divider + 1) system clocks: a low half of 2 × (divider + 1) clocks and then a high half of the same length. The data line changes only while the link clock is low, so it is stable at every rising edge. If another word is already waiting when the final bit of the current word ends, that word loads at once and follows with no idle gap.

Two status outputs report whether the buffer and the shift stage are empty. The buffer-empty flag rises when its word moves to the shift stage. It falls only when a new word is written.

Top module: `sync_master_tx`

## Requirements
- R1: Shifting happens only while all four of cfg_sync, cfg_port_en, cfg_clk_master and cfg_tx_en are 1. Whenever any of them is 0, the link clock stays low and shreg_empty stays 1. A word may still be written into the buffer in that state.
- R2: rx_inhibit is 1 exactly while a word is in the shift stage (shreg_empty = 0), and 0 otherwise.
- R3: A buffered word moves to the shift stage in one system cycle, either when the shift stage is empty or at the end of the final bit of the previous word. On that same edge buf_empty becomes 1.
- R4: buf_empty falls only on an accepted write (wr_valid and wr_ready both 1 at a clock edge). It never falls by itself after a word has been sent.
- R5: wr_ready equals buf_empty. A write offered while wr_ready is 0 is dropped, and the buffered word is kept unchanged.
- R6: Bits leave least significant first: wr_data bit 0 up to bit 7. line_data changes only while line_clk is low, and each bit is valid at the rising edge of line_clk.
- R7: With cfg_nine = 1 at load time, the word is 9 bits long and its last bit is wr_bit8. With cfg_nine = 0, wr_bit8 is not sent.
- R8: Consecutive rising edges of line_clk are 4 × (cfg_divider + 1) system clocks apart. line_clk is high for 2 × (cfg_divider + 1) clocks per bit.
- R9: A word written while the previous word is still shifting follows it with no gap. The rising-edge spacing across the word boundary equals the normal bit period.
- R10: Clearing cfg_tx_en during a word abandons that word within one cycle. shreg_empty and line_clk go to 1 and 0, and line_data keeps its last value.
- R11: After reset, buf_empty = 1, shreg_empty = 1, wr_ready = 1, rx_inhibit = 0, line_clk = 0 and line_data = 0.
- R12: line_clk is low whenever the shift stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sync | input | 1 | Synchronous mode select |
| cfg_port_en | input | 1 | Serial port enable |
| cfg_clk_master | input | 1 | Block sources the link clock |
| cfg_tx_en | input | 1 | Transmit enable; 0 aborts the current word |
| cfg_nine | input | 1 | 9-bit word mode, sampled when a word loads |
| cfg_divider | input | DIV_W | Bit-rate divider |
| wr_valid | input | 1 | Write offer of a word |
| wr_ready | output | 1 | Holding buffer can take a word |
| wr_data | input | 8 | Data byte |
| wr_bit8 | input | 1 | Ninth bit, stored with the byte |
| line_clk | output | 1 | Link clock, idles low |
| line_data | output | 1 | Link data |
| buf_empty | output | 1 | Holding buffer empty |
| shreg_empty | output | 1 | Shift stage empty |
| rx_inhibit | output | 1 | Receive must be held off |

## Verification
A table of words is sent with several divider values: 0, 1, 2, 3 and 5. The table mixes 8-bit and 9-bit modes and bytes with isolated ones, all ones, and alternating patterns. Sampling at each rising edge shows whether the bit order and the ninth-bit handling are right, and counting cycles shows whether the half-periods scale with the divider. A pair of words written back to back shows whether the buffered word reloads without a gap. Directed cases cover four more behaviours: a mode bit held low, a write refused because the buffer is full, an abort part-way through a word, and the flag staying set while the block is idle.

// File: rtl/smtx_pkg.sv
package smtx_pkg;
  parameter int unsigned SMTX_DATA_W = 8;

  typedef struct packed {
    logic                   ext;
    logic [SMTX_DATA_W-1:0] body;
  } smtx_word_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} smtx_phase_e;
endpackage

// File: rtl/smtx_baud.sv
module smtx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_last;

  // half period = 2*(divider+1) clocks, last count = 2*divider+1
  assign half_last = {divider, 1'b1};
  assign tick      = run && (cnt == half_last);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/smtx_holdbuf.sv
module smtx_holdbuf
  import smtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  smtx_word_t wr_word,
  output logic       wr_ready,
  input  logic       take,
  output logic       full,
  output smtx_word_t word
);
  assign wr_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (wr_valid && wr_ready) begin
      full <= 1'b1;
      word <= wr_word;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  p_take_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  p_fill_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_valid));
  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(word)));
endmodule

// File: rtl/smtx_shifter.sv
module smtx_shifter
  import smtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       nine,
  input  logic       word_avail,
  input  smtx_word_t word_i,
  output logic       take,
  output logic       busy,
  output logic       line_clk,
  output logic       line_data
);
  localparam int unsigned WORD_W = SMTX_DATA_W + 1;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  smtx_phase_e       phase;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] word_v;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              last_bit;
  logic              word_end;

  assign word_v   = word_i;
  assign last_bit = (bit_idx == last_idx);
  assign word_end = busy && tick && (phase == PH_HIGH) && last_bit;
  assign take     = enable && word_avail && (!busy || word_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= PH_LOW;
      shreg     <= '0;
      bit_idx   <= '0;
      last_idx  <= IDX_W'(SMTX_DATA_W - 1);
      line_clk  <= 1'b0;
      line_data <= 1'b0;
    end else if (!enable) begin
      busy     <= 1'b0;
      phase    <= PH_LOW;
      bit_idx  <= '0;
      line_clk <= 1'b0;
    end else if (take) begin
      busy      <= 1'b1;
      phase     <= PH_LOW;
      line_clk  <= 1'b0;
      line_data <= word_v[0];
      shreg     <= word_v >> 1;
      bit_idx   <= '0;
      last_idx  <= nine ? IDX_W'(SMTX_DATA_W) : IDX_W'(SMTX_DATA_W - 1);
    end else if (busy && tick) begin
      if (phase == PH_LOW) begin
        phase    <= PH_HIGH;
        line_clk <= 1'b1;
      end else begin
        phase    <= PH_LOW;
        line_clk <= 1'b0;
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          bit_idx   <= bit_idx + 1'b1;
          line_data <= shreg[0];
          shreg     <= shreg >> 1;
        end
      end
    end
  end

  p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_clk |-> $stable(line_data));
  p_clk_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_clk);
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !line_clk));
  p_load_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy && !line_clk));
endmodule

// File: rtl/sync_master_tx.sv
module sync_master_tx
  import smtx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_sync,
  input  logic                   cfg_port_en,
  input  logic                   cfg_clk_master,
  input  logic                   cfg_tx_en,
  input  logic                   cfg_nine,
  input  logic [DIV_W-1:0]       cfg_divider,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [SMTX_DATA_W-1:0] wr_data,
  input  logic                   wr_bit8,
  output logic                   line_clk,
  output logic                   line_data,
  output logic                   buf_empty,
  output logic                   shreg_empty,
  output logic                   rx_inhibit
);
  logic       active;
  logic       take;
  logic       full;
  logic       busy;
  logic       tick;
  smtx_word_t in_word;
  smtx_word_t held_word;

  assign active  = cfg_sync && cfg_port_en && cfg_clk_master && cfg_tx_en;
  assign in_word = '{ext: wr_bit8, body: wr_data};

  smtx_holdbuf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_word  (in_word),
    .wr_ready (wr_ready),
    .take     (take),
    .full     (full),
    .word     (held_word)
  );

  smtx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .divider (cfg_divider),
    .tick    (tick)
  );

  smtx_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (active),
    .tick       (tick),
    .nine       (cfg_nine),
    .word_avail (full),
    .word_i     (held_word),
    .take       (take),
    .busy       (busy),
    .line_clk   (line_clk),
    .line_data  (line_data)
  );

  assign buf_empty   = !full;
  assign shreg_empty = !busy;
  assign rx_inhibit  = busy;

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (shreg_empty && !line_clk));
  p_flag_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !shreg_empty);
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(wr_valid && wr_ready));
  p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_clk |-> rx_inhibit);
endmodule

// File: tb/sync_master_tx_test.sv
module sync_master_tx_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sync = 1'b1, cfg_port_en = 1'b1, cfg_clk_master = 1'b1;
  logic       cfg_tx_en = 1'b0, cfg_nine = 1'b0;
  logic [7:0] cfg_divider = 8'd0;
  logic       wr_valid = 1'b0, wr_bit8 = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, line_clk, line_data, buf_empty, shreg_empty, rx_inhibit;

  int checks_n = 0;
  int fails_n  = 0;

  // {divider, nine, bit8, data}
  localparam logic [17:0] VEC [6] = '{
    {8'd0, 1'b0, 1'b0, 8'hA5},
    {8'd1, 1'b0, 1'b0, 8'h3C},
    {8'd3, 1'b1, 1'b1, 8'h81},
    {8'd0, 1'b1, 1'b0, 8'hFF},
    {8'd2, 1'b0, 1'b1, 8'h01},
    {8'd5, 1'b1, 1'b1, 8'h6E}
  };

  sync_master_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_port_en(cfg_port_en),
    .cfg_clk_master(cfg_clk_master), .cfg_tx_en(cfg_tx_en), .cfg_nine(cfg_nine),
    .cfg_divider(cfg_divider), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .line_clk(line_clk),
    .line_data(line_data), .buf_empty(buf_empty), .shreg_empty(shreg_empty),
    .rx_inhibit(rx_inhibit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks_n - fails_n, checks_n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks_n++; fails_n++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks_n++;
    if (!ok) begin
      fails_n++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic b8);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit8 = b8;
    for (int i = 0; i < 5000 && !wr_ready; i++) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic capture(input int nbits, input int div, output logic [17:0] bits,
                         output int got, output int bad_gap, output int hi_cnt,
                         output int inhib_bad, output int flag_bad);
    logic prev;
    int   last_rise;
    int   cyc;
    bits = '0; got = 0; bad_gap = 0; hi_cnt = 0; inhib_bad = 0; flag_bad = 0;
    prev = line_clk; last_rise = 0; cyc = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cyc++;
      if (line_clk) hi_cnt++;
      if (!shreg_empty != rx_inhibit) inhib_bad++;
      if (line_clk && !prev && got < 18) begin
        bits[got] = line_data;
        if (got == 0 && !buf_empty) flag_bad++;
        if (got > 0 && (cyc - last_rise) != 4 * (div + 1)) bad_gap++;
        last_rise = cyc;
        got++;
      end
      prev = line_clk;
      if (got >= nbits && !line_clk && shreg_empty) break;
    end
  endtask

  initial begin
    logic [17:0] bits;
    logic [17:0] exp_bits;
    int got, bad_gap, hi_cnt, inhib_bad, flag_bad, nb, dv;
    logic held;

    repeat (3) @(negedge clk);
    // R11 reset state, sampled while reset is held
    check(buf_empty && shreg_empty && wr_ready && !rx_inhibit && !line_clk && !line_data,
          "R11 reset outputs", {buf_empty, shreg_empty, wr_ready, rx_inhibit, line_clk, line_data},
          6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(buf_empty && shreg_empty && !line_clk, "R11 after reset release",
          {buf_empty, shreg_empty, line_clk}, 3'b110);

    // table of words: R6 R7 R8 R2 R3
    cfg_tx_en = 1'b1;
    foreach (VEC[k]) begin
      dv = int'(VEC[k][17:10]);
      cfg_divider = VEC[k][17:10];
      cfg_nine    = VEC[k][9];
      nb = VEC[k][9] ? 9 : 8;
      exp_bits = '0;
      for (int b = 0; b < 8; b++) exp_bits[b] = VEC[k][b];
      if (VEC[k][9]) exp_bits[8] = VEC[k][8];
      push(VEC[k][7:0], VEC[k][8]);
      capture(nb, dv, bits, got, bad_gap, hi_cnt, inhib_bad, flag_bad);
      check(got == nb, "R7 bit count", got, nb);
      check(bits == exp_bits, "R6 R7 bit order", bits, exp_bits);
      check(bad_gap == 0, "R8 rise spacing", bad_gap, 0);
      check(hi_cnt == nb * 2 * (dv + 1), "R8 high time", hi_cnt, nb * 2 * (dv + 1));
      check(inhib_bad == 0, "R2 rx_inhibit tracks shift stage", inhib_bad, 0);
      check(flag_bad == 0, "R3 buf_empty set by first rise", flag_bad, 0);
    end

    // R4: flag stays set while idle
    repeat (20) @(negedge clk);
    check(buf_empty && wr_ready && shreg_empty, "R4 flag stays set idle",
          {buf_empty, wr_ready, shreg_empty}, 3'b111);

    // R9: back to back words
    cfg_divider = 8'd1; cfg_nine = 1'b0;
    push(8'h5A, 1'b0);
    push(8'hC3, 1'b0);
    capture(16, 1, bits, got, bad_gap, hi_cnt, inhib_bad, flag_bad);
    check(got == 16, "R9 two words count", got, 16);
    check(bits[15:0] == 16'hC35A, "R9 two words bits", bits[15:0], 16'hC35A);
    check(bad_gap == 0, "R9 no gap between words", bad_gap, 0);

    // R1: mode bit low, word held in buffer only
    cfg_clk_master = 1'b0; cfg_divider = 8'd0;
    push(8'h96, 1'b0);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (line_clk || !shreg_empty) got++;
    end
    check(got == 0, "R1 no shifting with mode bit low", got, 0);
    check(!buf_empty, "R1 buffer accepted write", buf_empty, 0);
    cfg_clk_master = 1'b1;
    capture(8, 0, bits, got, bad_gap, hi_cnt, inhib_bad, flag_bad);
    check(bits[7:0] == 8'h96, "R1 word sent once enabled", bits[7:0], 8'h96);

    // R5: refused write while full
    cfg_tx_en = 1'b0;
    push(8'h0F, 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hF0;
    got = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (wr_ready) got++;
    end
    wr_valid = 1'b0;
    check(got == 0, "R5 ready low while full", got, 0);
    cfg_tx_en = 1'b1;
    capture(8, 0, bits, got, bad_gap, hi_cnt, inhib_bad, flag_bad);
    check(bits[7:0] == 8'h0F, "R5 buffered word kept", bits[7:0], 8'h0F);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (line_clk || !shreg_empty) got++;
    end
    check(got == 0, "R5 refused word never sent", got, 0);

    // R10: abort mid-word
    cfg_divider = 8'd2;
    push(8'hAA, 1'b0);
    got = 0;
    for (int i = 0; i < 500 && got < 3; i++) begin
      held = line_clk;
      @(negedge clk);
      if (line_clk && !held) got++;
    end
    held = line_data;
    cfg_tx_en = 1'b0;
    @(negedge clk);
    check(shreg_empty && !line_clk && !rx_inhibit, "R10 abort empties shift stage",
          {shreg_empty, line_clk, rx_inhibit}, 3'b100);
    check(line_data == held, "R10 data held after abort", line_data, held);
    check(!line_clk, "R12 clock low when empty", line_clk, 0);

    summary();
    $finish;
  end
endmodule